// File: doc/BRIEF.md
# Command Completion Tally with Level Interrupt

This block keeps the per-channel completion bookkeeping of a list-driven DMA engine. The engine pulses a one-cycle event each time it loads a command list or finishes a command. Each pulse advances a 6-bit completion count and raises a pending flag. The pending flag drives a level-sensitive, active-high interrupt. Software reads one status word that holds the completion count, the acknowledged count and the pending flag.

Software acknowledges through the same word. It writes back the completion count it last saw into the acknowledged field and writes a zero to the pending bit. Both counts wrap modulo 64, so software can retire several completions in one write. The number still outstanding is (completion - acknowledged) mod 64. A completion can land between software's read and its write. The completion field is owned by hardware alone, so it keeps counting across the write, and software can find the race by reading the word again.

Top module: `cmd_tally_status`

## Requirements
- R1: After reset the status word reads all zeros and the interrupt output is low.
- R2: Each cycle with the done event high raises the completion count (status bits 5:0) by one. The new value is readable from the following cycle. With no event the count holds.
- R3: The completion count wraps from 63 to 0.
- R4: A register write loads status bits 21:16 (the acknowledged count) from write-data bits 21:16, visible from the following cycle. With no write the field holds.
- R5: A register write never changes the completion count, whatever write-data bits 5:0 hold.
- R6: A write with write-data bit 8 at zero clears the pending flag (status bit 8). A write with bit 8 at one leaves the flag unchanged.
- R7: A done event sets the pending flag. When it coincides with a clearing write, the flag ends up set.
- R8: The interrupt output is high exactly while the pending flag is set.
- R9: Status bits other than 21:16, 8 and 5:0 always read zero.
- R10: A done event in the same cycle as a write still advances the completion count, and the acknowledged field takes the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| doneEvt | input | 1 | One-cycle pulse per list load or command completion |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 32 | Register write data |
| rdData | output | 32 | Status word: completion count, pending flag, acknowledged count |
| irqOut | output | 1 | Level interrupt, active high |

## Verification
If the completion count misses an event or steps twice, the low field of the status word is off from the next cycle. That error stays until reset, because nothing in the block ever corrects it. If the flag priority is wrong, a done event that coincides with a clearing write leaves the interrupt low on the very next cycle and the completion is lost. If a write reaches the completion field, the low field changes on the cycle after a write that carries nonzero low data.

// File: rtl/cmd_tally_pkg.sv
package cmd_tally_pkg;
  typedef struct packed {
    logic incDone;
    logic loadProc;
    logic clrFlag;
  } tally_strobe_t;
endpackage

// File: rtl/cmd_tally_ctrl.sv
module cmd_tally_ctrl
  import cmd_tally_pkg::*;
(
  input  logic          doneEvt,
  input  logic          wrEn,
  input  logic          wrFlagBit,
  output tally_strobe_t strobes
);
  always_comb begin
    strobes.incDone  = doneEvt;
    strobes.loadProc = wrEn;
    strobes.clrFlag  = wrEn & ~wrFlagBit;
  end
endmodule

// File: rtl/cmd_tally_dp.sv
module cmd_tally_dp
  import cmd_tally_pkg::*;
#(
  parameter int CNT_W    = 6,
  parameter int DATA_W   = 32,
  parameter int DONE_LSB = 0,
  parameter int FLAG_BIT = 8,
  parameter int PROC_LSB = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  tally_strobe_t     strobes,
  input  logic [CNT_W-1:0]  procIn,
  output logic [DATA_W-1:0] statusWord,
  output logic              flagOut
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] doneCnt;
  logic [CNT_W-1:0] procCnt;
  logic             pendFlag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneCnt  <= '0;
      procCnt  <= '0;
      pendFlag <= 1'b0;
    end else begin
      if (strobes.incDone)  doneCnt <= doneCnt + ONE;
      if (strobes.loadProc) procCnt <= procIn;
      if (strobes.incDone)      pendFlag <= 1'b1;
      else if (strobes.clrFlag) pendFlag <= 1'b0;
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[DONE_LSB +: CNT_W] = doneCnt;
    statusWord[FLAG_BIT]          = pendFlag;
    statusWord[PROC_LSB +: CNT_W] = procCnt;
  end

  assign flagOut = pendFlag;
endmodule

// File: rtl/cmd_tally_status.sv
module cmd_tally_status
  import cmd_tally_pkg::*;
#(
  parameter int CNT_W    = 6,
  parameter int DATA_W   = 32,
  parameter int DONE_LSB = 0,
  parameter int FLAG_BIT = 8,
  parameter int PROC_LSB = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              doneEvt,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);
  tally_strobe_t strobes;

  cmd_tally_ctrl uCtrl (
    .doneEvt  (doneEvt),
    .wrEn     (wrEn),
    .wrFlagBit(wrData[FLAG_BIT]),
    .strobes  (strobes)
  );

  cmd_tally_dp #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .DONE_LSB(DONE_LSB),
    .FLAG_BIT(FLAG_BIT), .PROC_LSB(PROC_LSB)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .procIn    (wrData[PROC_LSB +: CNT_W]),
    .statusWord(rdData),
    .flagOut   (irqOut)
  );
endmodule

// File: rtl/cmd_tally_checker.sv
module cmd_tally_checker #(
  parameter int CNT_W    = 6,
  parameter int DATA_W   = 32,
  parameter int DONE_LSB = 0,
  parameter int FLAG_BIT = 8,
  parameter int PROC_LSB = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              doneEvt,
  input logic              wrEn,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic              irqOut
);
  logic [CNT_W-1:0] doneF, procF;
  assign doneF = rdData[DONE_LSB +: CNT_W];
  assign procF = rdData[PROC_LSB +: CNT_W];

  AST_DONE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    doneEvt |=> doneF == $past(doneF) + CNT_W'(1)); // R2
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !doneEvt |=> $stable(doneF)); // R5
  AST_PROC_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> procF == $past(wrData[PROC_LSB +: CNT_W])); // R4
  AST_PROC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(procF)); // R4
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN)
    doneEvt |=> irqOut); // R7
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrData[FLAG_BIT] && !doneEvt) |=> !irqOut); // R6
  AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (!doneEvt && !(wrEn && !wrData[FLAG_BIT])) |=> $stable(irqOut)); // R6
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == rdData[FLAG_BIT]); // R8
endmodule

bind cmd_tally_status cmd_tally_checker #(
  .CNT_W(CNT_W), .DATA_W(DATA_W), .DONE_LSB(DONE_LSB),
  .FLAG_BIT(FLAG_BIT), .PROC_LSB(PROC_LSB)
) uChk (
  .clk(clk), .rstN(rstN), .doneEvt(doneEvt), .wrEn(wrEn),
  .wrData(wrData), .rdData(rdData), .irqOut(irqOut)
);

// File: tb/cmd_tally_status_test.sv
module cmd_tally_status_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        doneEvt = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  logic [5:0] mDone = '0;
  logic [5:0] mProc = '0;
  logic       mFlag = 1'b0;

  always #2 clk = ~clk;

  cmd_tally_status uut (
    .clk(clk), .rstN(rstN), .doneEvt(doneEvt), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .irqOut(irqOut)
  );

  function automatic logic [31:0] packWord(logic [5:0] d, logic f, logic [5:0] p);
    logic [31:0] w = '0;
    w[5:0]   = d;
    w[8]     = f;
    w[21:16] = p;
    return w;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkAll();
    chk("R2 done field", {26'd0, rdData[5:0]}, {26'd0, mDone});
    chk("R4 ack field", {26'd0, rdData[21:16]}, {26'd0, mProc});
    chk("R6 flag bit", {31'd0, rdData[8]}, {31'd0, mFlag});
    chk("R8 irq level", {31'd0, irqOut}, {31'd0, mFlag});
    chk("R9 full word", rdData, packWord(mDone, mFlag, mProc));
  endtask

  task automatic step(logic ev, logic we, logic [31:0] d);
    doneEvt = ev; wrEn = we; wrData = d;
    @(posedge clk);
    #1;
    if (we) mProc = d[21:16];
    if (ev) begin
      mDone = mDone + 6'd1;
      mFlag = 1'b1;
    end else if (we && !d[8]) mFlag = 1'b0;
    @(negedge clk);
    doneEvt = 1'b0; wrEn = 1'b0; wrData = '0;
    checkAll();
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    @(negedge clk);
    @(negedge clk);
    chk("R1 reset word", rdData, 32'd0);
    chk("R1 reset irq", {31'd0, irqOut}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after release", rdData, 32'd0);

    // R7: one event sets the flag and the interrupt
    step(1'b1, 1'b0, '0);
    // R6: a write carrying bit 8 set leaves the flag up
    step(1'b0, 1'b1, 32'h0001_0100);
    // R5: garbage in the low write bits must not reach the done field
    step(1'b0, 1'b1, 32'hFFC0_FE3F & ~32'h0000_0100);
    // R9: the unused bits stay zero after the all-ones write above
    // R7, R10: event and clearing write together
    step(1'b1, 1'b1, 32'h0005_0000);
    chk("R7 coincident set", {31'd0, irqOut}, 32'd1);
    // R6: plain clearing write
    step(1'b0, 1'b1, {10'd0, mDone, 16'd0});
    chk("R6 cleared irq", {31'd0, irqOut}, 32'd0);
    // R3: run the count around through 63 to 0
    for (int i = 0; i < 70; i++) step(1'b1, 1'b0, '0);
    chk("R3 wrap count", {26'd0, rdData[5:0]}, {26'd0, 6'(72)});

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic ev, we;
      logic [31:0] d;
      ev = ($urandom % 3) == 0;
      we = ($urandom % 4) == 0;
      d  = $urandom;
      if ($urandom % 2) d[21:16] = mDone;
      step(ev, we, d);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule